// File: doc/BRIEF.md
# Interrupt Enable and Status Bank

This block gathers 64 already-conditioned interrupt lines and turns them into a single active-high level request for a parent interrupt controller. The lines form two 32-bit halves. Each half has its own six-word register window. The window shows the raw status and the masked status. It also holds the enable mask and a software-pending vector, and software changes each of these only through a pair of write-one-to-set and write-one-to-clear words. Software never needs a read-modify-write to change one line without disturbing the others.

Three copies are meant to sit side by side on one shared conditioned-input bus, each with its own enable mask and its own upward request. Software first clears every enable with one all-ones write per half. It then opens the lines it wants. When the request rises, it reads the masked status of both halves to find the sources.

The bus is a simple synchronous word-addressed port. Writes take effect at the clock edge where `wr_en` is high. Read data is a combinational function of `addr` and the current state.

Top module: `irq_mask_bank`

## Requirements
- R1: After reset, every enable bit and every software-pending bit is 0, and `irq_req` is 0.
- R2: A write to word 2 (low half) or word 8 (high half) sets each enable bit whose write-data bit is 1. Bits written as 0 keep their value.
- R3: A write to word 3 (low half) or word 9 (high half) clears each enable bit whose write-data bit is 1. Writing all ones to both words disables all 64 lines.
- R4: Reading word 2 or word 3 returns the low-half enable vector. Reading word 8 or word 9 returns the high-half enable vector.
- R5: Writes to word 4/10 set pending bits and writes to word 5/11 clear pending bits, for the low/high half, with write-one semantics. Reading any of these four words returns that half's pending vector.
- R6: Word 1 (low half) and word 7 (high half) read the raw status, which is the input lines OR the pending bits.
- R7: Word 0 (low half) and word 6 (high half) read the masked status, which is the raw status AND the enables.
- R8: `irq_req` is high in the cycle after a clock edge at which any of the 64 masked status bits was 1, and low otherwise.
- R9: Words 12 to 63 read as 0, and writes to them change no state.
- R10: The high-half words (6 to 11) sit six words (24 bytes) above the low-half words, map to lines 32 to 63, and never change low-half state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 64 | Conditioned interrupt lines; bit n is line n |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 6 | Word address inside the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq_req | output | 1 | Registered active-high level request to the parent |

## Verification
The bench uses the default parameters: 64 lines in two 32-bit halves and a 6-bit word address. The random phase draws addresses from 0 to 15, so it covers both halves and the first few unmapped words, including writes to them. Sparse random line patterns together with random set and clear writes let the request both rise and fall, through line inputs and through software-pending bits. Directed steps cover the all-ones disable and the isolation between the two halves.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

    localparam int unsigned WORDS_PER_HALF = 6;

    typedef enum logic [2:0] {
        K_MASKED = 3'd0,
        K_RAW    = 3'd1,
        K_ENSET  = 3'd2,
        K_ENCLR  = 3'd3,
        K_SSET   = 3'd4,
        K_SCLR   = 3'd5,
        K_NONE   = 3'd7
    } irqb_kind_e;

endpackage

// File: rtl/irqb_decode.sv
module irqb_decode
    import irqb_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned HALVES = 2,
    localparam int unsigned HI_W  = (HALVES > 1) ? $clog2(HALVES) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [HI_W-1:0]   half,
    output irqb_kind_e        kind
);
    localparam int unsigned MAPPED = HALVES * WORDS_PER_HALF;

    int unsigned word;

    always_comb begin
        word = 32'(addr);
        hit  = (word < MAPPED);
        half = '0;
        kind = K_NONE;
        if (hit) begin
            half = HI_W'(word / WORDS_PER_HALF);
            kind = irqb_kind_e'(3'(word % WORDS_PER_HALF));
        end
    end
endmodule

// File: rtl/irqb_half.sv
module irqb_half #(
    parameter int unsigned HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] lines,
    input  logic [HALF_W-1:0] wdata,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic              wr_pset,
    input  logic              wr_pclr,
    output logic [HALF_W-1:0] en,
    output logic [HALF_W-1:0] pend,
    output logic [HALF_W-1:0] raw,
    output logic [HALF_W-1:0] masked
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= '0;
            pend <= '0;
        end else begin
            if (wr_set)  en   <= en | wdata;
            if (wr_clr)  en   <= en & ~wdata;
            if (wr_pset) pend <= pend | wdata;
            if (wr_pclr) pend <= pend & ~wdata;
        end
    end

    always_comb begin
        raw    = lines | pend;
        masked = raw & en;
    end

    a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((en & $past(wdata)) == $past(wdata)));

    a_r2_zero_bits_keep: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((en & ~$past(wdata)) == ($past(en) & ~$past(wdata))));

    a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((en & $past(wdata)) == '0));

    a_r5_soft_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pset |=> ((pend & $past(wdata)) == $past(wdata)));

    a_r5_soft_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pclr |=> ((pend & $past(wdata)) == '0));

    a_r9_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(en));

    a_r9_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_pset || wr_pclr) |=> $stable(pend));
endmodule

// File: rtl/irqb_request.sv
module irqb_request #(
    parameter int unsigned LINES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] masked_all,
    output logic             irq_req
);
    always_ff @(posedge clk) begin
        if (!rst_n) irq_req <= 1'b0;
        else        irq_req <= |masked_all;
    end

    a_r8_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_all == '0) |=> !irq_req);

    a_r8_raise_on_source: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_all != '0) |=> irq_req);
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irqb_pkg::*;
#(
    parameter int unsigned LINES  = 64,
    parameter int unsigned HALF_W = 32,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  line_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] rdata,
    output logic              irq_req
);
    localparam int unsigned HALVES = LINES / HALF_W;
    localparam int unsigned HI_W   = (HALVES > 1) ? $clog2(HALVES) : 1;
    localparam int unsigned MAPPED = HALVES * WORDS_PER_HALF;

    logic            dec_hit;
    logic [HI_W-1:0] dec_half;
    irqb_kind_e      dec_kind;

    logic [HALF_W-1:0] en_h     [HALVES];
    logic [HALF_W-1:0] pend_h   [HALVES];
    logic [HALF_W-1:0] raw_h    [HALVES];
    logic [HALF_W-1:0] masked_h [HALVES];
    logic [LINES-1:0]  masked_all;

    irqb_decode #(
        .ADDR_W (ADDR_W),
        .HALVES (HALVES)
    ) u_decode (
        .addr (addr),
        .hit  (dec_hit),
        .half (dec_half),
        .kind (dec_kind)
    );

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic sel;
        assign sel = wr_en && dec_hit && (dec_half == HI_W'(h));

        irqb_half #(
            .HALF_W (HALF_W)
        ) u_half (
            .clk     (clk),
            .rst_n   (rst_n),
            .lines   (line_in[h*HALF_W +: HALF_W]),
            .wdata   (wdata),
            .wr_set  (sel && (dec_kind == K_ENSET)),
            .wr_clr  (sel && (dec_kind == K_ENCLR)),
            .wr_pset (sel && (dec_kind == K_SSET)),
            .wr_pclr (sel && (dec_kind == K_SCLR)),
            .en      (en_h[h]),
            .pend    (pend_h[h]),
            .raw     (raw_h[h]),
            .masked  (masked_h[h])
        );

        assign masked_all[h*HALF_W +: HALF_W] = masked_h[h];
    end

    irqb_request #(
        .LINES (LINES)
    ) u_request (
        .clk        (clk),
        .rst_n      (rst_n),
        .masked_all (masked_all),
        .irq_req    (irq_req)
    );

    always_comb begin
        rdata = '0;
        if (dec_hit) begin
            unique case (dec_kind)
                K_MASKED:        rdata = masked_h[dec_half];
                K_RAW:           rdata = raw_h[dec_half];
                K_ENSET,
                K_ENCLR:         rdata = en_h[dec_half];
                K_SSET,
                K_SCLR:          rdata = pend_h[dec_half];
                default:         rdata = '0;
            endcase
        end
    end

    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= ADDR_W'(MAPPED)) |-> (rdata == '0));

    a_r4_alias_words_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_hit && (dec_kind == K_ENCLR)) |-> (rdata == en_h[dec_half]));
endmodule

// File: tb/tb_irq_mask_bank.sv
module tb_irq_mask_bank;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] line_in;
    logic        wr_en;
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq_req;

    int checks = 0;
    int errors = 0;

    logic [63:0] m_en, m_pd;
    logic        m_req;

    always #5 clk = ~clk;

    irq_mask_bank dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq_req (irq_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (addr %0d)", tag, act, exp, addr);
        end
    endtask

    function automatic string tag_of(input int a);
        if (a >= 12) return "R9";
        case (a % 6)
            0: return "R7";
            1: return "R6";
            2, 3: return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic logic [31:0] model_read(input int a, input logic [63:0] ln);
        logic [63:0] raw;
        int b;
        raw = ln | m_pd;
        if (a >= 12) return 32'h0;
        b = (a / 6) * 32;
        case (a % 6)
            0: return ((raw & m_en) >> b) & 64'hFFFF_FFFF;
            1: return (raw >> b) & 64'hFFFF_FFFF;
            2, 3: return (m_en >> b) & 64'hFFFF_FFFF;
            default: return (m_pd >> b) & 64'hFFFF_FFFF;
        endcase
    endfunction

    task automatic step(input logic w, input int a, input logic [31:0] d, input logic [63:0] ln);
        logic nreq;
        int b;
        @(negedge clk);
        wr_en = w; addr = 6'(a); wdata = d; line_in = ln;
        #1;
        check(tag_of(a), rdata, model_read(a, ln));
        check("R8", {31'b0, irq_req}, {31'b0, m_req});
        nreq = |((ln | m_pd) & m_en);
        if (w && a < 12) begin
            b = (a / 6) * 32;
            case (a % 6)
                2: m_en[b +: 32] = m_en[b +: 32] | d;
                3: m_en[b +: 32] = m_en[b +: 32] & ~d;
                4: m_pd[b +: 32] = m_pd[b +: 32] | d;
                5: m_pd[b +: 32] = m_pd[b +: 32] & ~d;
                default: ;
            endcase
        end
        m_req = nreq;
    endtask

    task automatic expect_rd(input string tag, input int a, input logic [63:0] ln, input logic [31:0] exp);
        step(1'b0, a, 32'h0, ln);
        check(tag, rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; line_in = '0;
        m_en = '0; m_pd = '0; m_req = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_rd("R1", 2, 64'h0, 32'h0);
        expect_rd("R1", 10, 64'h0, 32'h0);
        check("R1", {31'b0, irq_req}, 32'h0);

        // R2 set, then zero bits keep
        step(1'b1, 2, 32'h0000_00F0, 64'h0);
        step(1'b1, 2, 32'h0000_0000, 64'h0);
        expect_rd("R2", 2, 64'h0, 32'h0000_00F0);
        // R10 high half untouched
        expect_rd("R10", 8, 64'h0, 32'h0);
        // R6 / R7 low half
        expect_rd("R6", 1, 64'h3, 32'h3);
        expect_rd("R7", 0, 64'h30, 32'h30);
        // R8 rise then fall
        step(1'b0, 0, 32'h0, 64'h10);
        step(1'b0, 0, 32'h0, 64'h10);
        check("R8", {31'b0, irq_req}, 32'h1);
        step(1'b0, 0, 32'h0, 64'h1);
        step(1'b0, 0, 32'h0, 64'h1);
        check("R8", {31'b0, irq_req}, 32'h0);

        // R5 high-half pending, R10 lines 32..63
        step(1'b1, 10, 32'h8000_0001, 64'h0);
        expect_rd("R5", 11, 64'h0, 32'h8000_0001);
        expect_rd("R6", 7, 64'h0, 32'h8000_0001);
        expect_rd("R7", 6, 64'h0, 32'h0);
        expect_rd("R10", 4, 64'h0, 32'h0);
        step(1'b1, 8, 32'h0000_0001, 64'h0);
        expect_rd("R7", 6, 64'h0, 32'h0000_0001);
        step(1'b0, 0, 32'h0, 64'h0);
        check("R8", {31'b0, irq_req}, 32'h1);
        step(1'b1, 11, 32'h0000_0001, 64'h0);
        expect_rd("R5", 10, 64'h0, 32'h8000_0000);

        // R3 all-ones disable of both halves
        step(1'b1, 9, 32'hFFFF_FFFF, 64'h0);
        step(1'b1, 3, 32'hFFFF_FFFF, 64'h0);
        expect_rd("R3", 2, 64'h0, 32'h0);
        expect_rd("R3", 8, 64'h0, 32'h0);
        expect_rd("R3", 0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0);

        // R9 unmapped write ignored
        step(1'b1, 12, 32'hFFFF_FFFF, 64'h0);
        step(1'b1, 63, 32'hFFFF_FFFF, 64'h0);
        expect_rd("R9", 12, 64'h0, 32'h0);
        expect_rd("R9", 2, 64'h0, 32'h0);
        expect_rd("R9", 4, 64'h0, 32'h0);
        step(1'b1, 11, 32'hFFFF_FFFF, 64'h0);

        // random traffic compared on every clock
        for (int i = 0; i < 4000; i++) begin
            step(1'($urandom_range(0, 1)), int'($urandom_range(0, 15)), $urandom,
                 {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule